// File: doc/BRIEF.md
# Scroll and VRAM Address Register

This block keeps the scroll position and video-memory pointer of a tile-based video processor. It holds a 15-bit current address, a 15-bit temporary address, a 3-bit fine horizontal scroll and one write toggle that is shared by the two-write scroll port and the two-write address port. The current address is split into fields. Coarse X occupies bits 4:0 and coarse Y occupies bits 9:5. Bit 10 selects the horizontal name table and bit 11 selects the vertical one. Fine Y occupies bits 14:12.

A CPU-side register interface writes the temporary address through a control register, a scroll register and an address register. A status-read strobe rewinds the toggle, and a data-port strobe advances the pointer. The timing generator supplies a dot counter and a scanline counter. During rendering these counters drive the coarse X steps, the row steps and the reloads from the temporary register. The block presents the current address and fine X. It also presents two addresses derived from the current address: the name-table fetch address and the attribute fetch address. The tile fetcher uses both.

Each clock cycle is one dot.

Top module: `scroll_addr_unit`

## Requirements
- R1: While `rst` is high on an edge, the block clears the current address, the temporary address, fine X, the toggle and the 32-stride select, and it cancels any pending address commit. After that edge, `nt_addr` reads 0x2000 and `at_addr` reads 0x23C0.
- R2: A write is an edge with `cpu_we` high. The write targets the register that `cpu_sel` names: 0 is control, 1 is scroll, 2 is address, and 3 has no effect. A scroll write with the toggle clear sets fine X from data bits 2:0 and temp bits 4:0 from data bits 7:3. A scroll write with the toggle set loads temp bits 9:5 from data bits 7:3 and temp bits 14:12 from data bits 2:0.
- R3: An address write with the toggle clear loads temp bits 13:8 from data bits 5:0 and zeroes temp bit 14. With the toggle set, it loads temp bits 7:0. That second write also arms a commit of the whole new temp value. If the second write is taken at edge k, `vaddr` shows the new value after edge k+2. A later second write restarts the delay.
- R4: A control write places data bits 1:0 into temp bits 11:10. It also latches data bit 2 as the stride select: set means 32, clear means 1.
- R5: The toggle inverts on every scroll or address write. A status read clears the toggle, and this wins over a write in the same cycle. That write still uses the toggle value from before the cycle.
- R6: A coarse X step turns coarse X (bits 4:0) from 31 to 0 and inverts bit 10. For any other coarse X value, it adds 1.
- R7: A vertical step adds 1 to fine Y (bits 14:12) while fine Y is below 7. Otherwise it zeroes fine Y and advances coarse Y (bits 9:5) as follows. From 29, coarse Y goes to 0 and bit 11 inverts. From 31, coarse Y goes to 0 and bit 11 is untouched. From any other value, coarse Y adds 1.
- R8: Rendering means `render_en` is high and the line is either a visible line (below 240) or the pre-render line (261). While rendering, a coarse X step happens at every nonzero dot that is a multiple of 8 up to 256, and at dots 328 and 336. Dot 256 also applies a vertical step after the coarse X step.
- R9: While rendering, dot 257 copies bits 10 and 4:0 from temp into the current address.
- R10: While rendering on the pre-render line, every dot from 280 to 304 copies bits 14:11 and 9:5 from temp into the current address.
- R11: When rendering is off, a data-port access adds the stride to the current address, wrapping at 15 bits. During rendering, the same access applies one coarse X step and one vertical step together.
- R12: `nt_addr` equals 0x2000 OR current bits 11:0. `at_addr` equals 0x23C0 OR (bits 11:10 in place) OR (coarse Y bits 4:2 at bits 5:3) OR (coarse X bits 4:2 at bits 2:0). Both are registered and change on the same edge as `vaddr`.
- R13: Only one update reaches the current address in a cycle. A landing commit wins over a data-port access, and a data-port access wins over the dot schedule of R8 to R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_sel | input | 2 | Register select: 0 control, 1 scroll, 2 address, 3 none |
| cpu_wdata | input | 8 | Register write data |
| status_rd | input | 1 | Status-register read strobe |
| data_acc | input | 1 | Data-port read or write strobe |
| render_en | input | 1 | Background or sprite rendering enabled |
| dot | input | 9 | Dot within the line, 0 to 340 |
| line | input | 9 | Scanline, 0 to 261 |
| vaddr | output | 15 | Current video-memory address |
| fine_x | output | 3 | Fine horizontal scroll |
| nt_addr | output | 14 | Name-table fetch address |
| at_addr | output | 14 | Attribute fetch address |

## Verification
The hardest state to reach is a row wrap with fine Y at 7 and coarse Y at 29 or 31. An address write always clears bit 14, so the ports cannot load that state directly. The stimulus therefore writes it into temp through the second scroll write. It then walks the pre-render line with rendering on, so the dot 280 to 304 reload carries it into the current address, and the row step at dot 256 of line 0 triggers the wrap. A second hard case is a commit that lands exactly on dot 328. The stimulus reaches it by issuing the second address write on dot 326 with rendering enabled.

// File: rtl/scroll_pkg.sv
package scroll_pkg;

  localparam int ADDR_W    = 15;
  localparam int FETCH_W   = 14;
  localparam int CY_SEAM   = 29;

  localparam int DOT_ROW   = 256;
  localparam int DOT_HCOPY = 257;
  localparam int DOT_VC_LO = 280;
  localparam int DOT_VC_HI = 304;
  localparam int DOT_PRE0  = 328;
  localparam int DOT_PRE1  = 336;

  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_SCROLL = 2'd1;
  localparam logic [1:0] SEL_ADDR   = 2'd2;

  localparam logic [FETCH_W-1:0] NT_BASE = 14'h2000;
  localparam logic [FETCH_W-1:0] AT_BASE = 14'h23C0;

  typedef struct packed {
    logic [2:0] fine_y;
    logic       nt_y;
    logic       nt_x;
    logic [4:0] coarse_y;
    logic [4:0] coarse_x;
  } vpos_t;

  function automatic vpos_t step_x(vpos_t p);
    vpos_t r = p;
    if (p.coarse_x == 5'd31) begin
      r.coarse_x = 5'd0;
      r.nt_x     = ~p.nt_x;
    end else begin
      r.coarse_x = p.coarse_x + 5'd1;
    end
    return r;
  endfunction

  function automatic vpos_t step_y(vpos_t p);
    vpos_t r = p;
    if (p.fine_y != 3'd7) begin
      r.fine_y = p.fine_y + 3'd1;
    end else begin
      r.fine_y = 3'd0;
      if (p.coarse_y == 5'(CY_SEAM)) begin
        r.coarse_y = 5'd0;
        r.nt_y     = ~p.nt_y;
      end else if (p.coarse_y == 5'd31) begin
        r.coarse_y = 5'd0;
      end else begin
        r.coarse_y = p.coarse_y + 5'd1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/scroll_step.sv
module scroll_step
  import scroll_pkg::*;
(
  input  vpos_t cur,
  output vpos_t x_next,
  output vpos_t xy_next
);
  // horizontal step alone, and horizontal followed by row step
  always_comb begin
    x_next  = step_x(cur);
    xy_next = step_y(step_x(cur));
  end
endmodule

// File: rtl/scroll_commit.sv
module scroll_commit #(
  parameter int DW    = 15,
  parameter int DELAY = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic          fire,
  output logic [DW-1:0] fire_val
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else if (load) begin
      cnt_q  <= CW'(DELAY);
      pend_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - CW'(1);
    end
  end

  assign fire     = (cnt_q == CW'(1));
  assign fire_val = pend_q;

  // R1: reset leaves nothing pending
  a_r1_reset_cancels: assert property (@(posedge clk) rst |=> !fire);
  // R3: an arming write is never itself followed at once by a landing
  a_r3_no_early_fire: assert property (@(posedge clk) disable iff (rst)
    load |=> !fire);
endmodule

// File: rtl/scroll_fetch.sv
module scroll_fetch
  import scroll_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  vpos_t              nxt,
  output logic [FETCH_W-1:0] nt_addr,
  output logic [FETCH_W-1:0] at_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      nt_addr <= NT_BASE;
      at_addr <= AT_BASE;
    end else begin
      nt_addr <= NT_BASE | {2'b00, nxt.nt_y, nxt.nt_x, nxt.coarse_y, nxt.coarse_x};
      at_addr <= AT_BASE | {2'b00, nxt.nt_y, nxt.nt_x, 4'b0000,
                            nxt.coarse_y[4:2], nxt.coarse_x[4:2]};
    end
  end
endmodule

// File: rtl/scroll_addr_unit.sv
module scroll_addr_unit
  import scroll_pkg::*;
#(
  parameter int DOT_W      = 9,
  parameter int LINE_W     = 9,
  parameter int VIS_LINES  = 240,
  parameter int PRE_LINE   = 261,
  parameter int COMMIT_DLY = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_we,
  input  logic [1:0]         cpu_sel,
  input  logic [7:0]         cpu_wdata,
  input  logic               status_rd,
  input  logic               data_acc,
  input  logic               render_en,
  input  logic [DOT_W-1:0]   dot,
  input  logic [LINE_W-1:0]  line,
  output logic [ADDR_W-1:0]  vaddr,
  output logic [2:0]         fine_x,
  output logic [FETCH_W-1:0] nt_addr,
  output logic [FETCH_W-1:0] at_addr
);
  vpos_t v_q, t_q, v_nx, t_nx, v_x, v_xy;
  logic [2:0] fx_q, fx_nx;
  logic tog_q, tog_nx, inc32_q, inc32_nx;
  logic wr_ctrl, wr_scroll, wr_addr;
  logic rendering, dot_xstep, in_vcopy, fire;
  logic [ADDR_W-1:0] fire_val;

  assign wr_ctrl   = cpu_we && (cpu_sel == SEL_CTRL);
  assign wr_scroll = cpu_we && (cpu_sel == SEL_SCROLL);
  assign wr_addr   = cpu_we && (cpu_sel == SEL_ADDR);

  assign rendering = render_en &&
                     ((line < LINE_W'(VIS_LINES)) || (line == LINE_W'(PRE_LINE)));
  assign dot_xstep = ((dot != '0) && (dot <= DOT_W'(DOT_ROW)) && (dot[2:0] == 3'd0)) ||
                     (dot == DOT_W'(DOT_PRE0)) || (dot == DOT_W'(DOT_PRE1));
  assign in_vcopy  = (line == LINE_W'(PRE_LINE)) &&
                     (dot >= DOT_W'(DOT_VC_LO)) && (dot <= DOT_W'(DOT_VC_HI));

  scroll_step u_step (
    .cur     (v_q),
    .x_next  (v_x),
    .xy_next (v_xy)
  );

  scroll_commit #(.DW(ADDR_W), .DELAY(COMMIT_DLY)) u_commit (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_addr && tog_q),
    .load_val (t_nx),
    .fire     (fire),
    .fire_val (fire_val)
  );

  // temporary register, fine X, toggle and stride
  always_comb begin
    t_nx     = t_q;
    fx_nx    = fx_q;
    inc32_nx = inc32_q;
    tog_nx   = tog_q;
    if (wr_ctrl) begin
      {t_nx.nt_y, t_nx.nt_x} = cpu_wdata[1:0];
      inc32_nx               = cpu_wdata[2];
    end
    if (wr_scroll) begin
      if (!tog_q) begin
        fx_nx         = cpu_wdata[2:0];
        t_nx.coarse_x = cpu_wdata[7:3];
      end else begin
        t_nx.coarse_y = cpu_wdata[7:3];
        t_nx.fine_y   = cpu_wdata[2:0];
      end
    end
    if (wr_addr) begin
      if (!tog_q) t_nx[14:8] = {1'b0, cpu_wdata[5:0]};
      else        t_nx[7:0]  = cpu_wdata;
    end
    if (wr_scroll || wr_addr) tog_nx = ~tog_q;
    if (status_rd)            tog_nx = 1'b0;
  end

  // current address: commit, then data port, then dot schedule
  always_comb begin
    v_nx = v_q;
    if (fire) begin
      v_nx = vpos_t'(fire_val);
    end else if (data_acc) begin
      if (rendering) v_nx = v_xy;
      else           v_nx = vpos_t'(v_q + (inc32_q ? ADDR_W'(32) : ADDR_W'(1)));
    end else if (rendering) begin
      if (dot == DOT_W'(DOT_HCOPY)) begin
        v_nx.nt_x     = t_q.nt_x;
        v_nx.coarse_x = t_q.coarse_x;
      end else if (dot_xstep) begin
        v_nx = (dot == DOT_W'(DOT_ROW)) ? v_xy : v_x;
      end else if (in_vcopy) begin
        v_nx.fine_y   = t_q.fine_y;
        v_nx.nt_y     = t_q.nt_y;
        v_nx.coarse_y = t_q.coarse_y;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q     <= '0;
      t_q     <= '0;
      fx_q    <= '0;
      tog_q   <= 1'b0;
      inc32_q <= 1'b0;
    end else begin
      v_q     <= v_nx;
      t_q     <= t_nx;
      fx_q    <= fx_nx;
      tog_q   <= tog_nx;
      inc32_q <= inc32_nx;
    end
  end

  scroll_fetch u_fetch (
    .clk     (clk),
    .rst     (rst),
    .nxt     (v_nx),
    .nt_addr (nt_addr),
    .at_addr (at_addr)
  );

  assign vaddr  = v_q;
  assign fine_x = fx_q;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (v_q == '0 && t_q == '0 && fx_q == '0 && !tog_q));

  a_r5_status_clears_toggle: assert property (@(posedge clk) disable iff (rst)
    status_rd |=> !tog_q);

  a_r13_commit_lands: assert property (@(posedge clk) disable iff (rst)
    fire |=> (v_q == $past(fire_val)));

  a_r11_stride: assert property (@(posedge clk) disable iff (rst)
    (data_acc && !rendering && !fire) |=>
      (v_q == ADDR_W'($past(v_q) + ($past(inc32_q) ? ADDR_W'(32) : ADDR_W'(1)))));

  a_r6_xwrap_prefetch: assert property (@(posedge clk) disable iff (rst)
    (rendering && dot == DOT_W'(DOT_PRE0) && !data_acc && !fire && v_q.coarse_x == 5'd31) |=>
      (v_q.coarse_x == 5'd0 && v_q.nt_x != $past(v_q.nt_x)));

  a_r9_hreload: assert property (@(posedge clk) disable iff (rst)
    (rendering && dot == DOT_W'(DOT_HCOPY) && !data_acc && !fire) |=>
      (v_q.coarse_x == $past(t_q.coarse_x) && v_q.nt_x == $past(t_q.nt_x)));

  a_r12_fetch_tracks: assert property (@(posedge clk) disable iff (rst)
    (nt_addr[11:0] == v_q[11:0] && nt_addr[13:12] == 2'b10 &&
     at_addr[11:10] == v_q[11:10] && at_addr[5:3] == v_q[9:7] && at_addr[2:0] == v_q[4:2]));
endmodule

// File: tb/scroll_addr_unit_bench.sv
module scroll_addr_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_we = 1'b0;
  logic [1:0] cpu_sel = 2'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic status_rd = 1'b0;
  logic data_acc = 1'b0;
  logic render_en = 1'b0;
  logic [8:0] dot = 9'd0;
  logic [8:0] line = 9'd240;
  logic [14:0] vaddr;
  logic [2:0] fine_x;
  logic [13:0] nt_addr, at_addr;

  int checks = 0;
  int failures = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  scroll_addr_unit u_scroll_addr_unit (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .status_rd(status_rd), .data_acc(data_acc), .render_en(render_en),
    .dot(dot), .line(line), .vaddr(vaddr), .fine_x(fine_x),
    .nt_addr(nt_addr), .at_addr(at_addr)
  );

  // ---------------- behavioural reference ----------------
  int m_v, m_t, m_fx, m_tog, m_i32, m_cnt, m_pend;

  function automatic int xstep(int v);
    if (v % 32 == 31) return (v - 31) ^ 1024;
    return v + 1;
  endfunction

  function automatic int ystep(int v);
    int cy;
    cy = (v / 32) % 32;
    if (v / 4096 < 7) return v + 4096;
    v = v % 4096;
    if (cy == 29) return (v - 29 * 32) ^ 2048;
    if (cy == 31) return v - 31 * 32;
    return v + 32;
  endfunction

  always @(posedge clk) begin
    int nv, nt, d, l;
    bit rend;
    if (rst) begin
      m_v = 0; m_t = 0; m_fx = 0; m_tog = 0; m_i32 = 0; m_cnt = 0; m_pend = 0;
    end else begin
      d = dot; l = line;
      rend = render_en && (l < 240 || l == 261);
      nv = m_v;
      if (m_cnt == 1) nv = m_pend;
      else if (data_acc) nv = rend ? ystep(xstep(m_v)) : (m_v + (m_i32 ? 32 : 1)) % 32768;
      else if (rend) begin
        if (d >= 1 && d <= 256 && d % 8 == 0) begin
          nv = xstep(nv);
          if (d == 256) nv = ystep(nv);
        end
        if (d == 328 || d == 336) nv = xstep(nv);
        if (d == 257) nv = (m_v & ~1055) | (m_t & 1055);
        if (l == 261 && d >= 280 && d <= 304) nv = (m_v & ~32'h7BE0) | (m_t & 32'h7BE0);
      end
      nt = m_t;
      if (cpu_we) begin
        case (cpu_sel)
          2'd0: begin nt = (nt & ~32'hC00) | ((cpu_wdata % 4) * 1024); m_i32 = (cpu_wdata / 4) % 2; end
          2'd1: if (m_tog == 0) begin m_fx = cpu_wdata % 8; nt = (nt & ~31) | (cpu_wdata / 8); end
                else nt = (nt & ~32'h73E0) | ((cpu_wdata / 8) * 32) | ((cpu_wdata % 8) * 4096);
          2'd2: if (m_tog == 0) nt = (nt & 255) | ((cpu_wdata % 64) * 256);
                else nt = (nt & ~255) | cpu_wdata;
          default: ;
        endcase
      end
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (cpu_we && cpu_sel == 2'd2 && m_tog == 1) begin m_cnt = 2; m_pend = nt; end
      if (cpu_we && (cpu_sel == 2'd1 || cpu_sel == 2'd2)) m_tog = 1 - m_tog;
      if (status_rd) m_tog = 0;
      m_v = nv; m_t = nt;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(cur_req, "vaddr", int'(vaddr), m_v);
      chk(cur_req, "fine_x", int'(fine_x), m_fx);
      chk("R12", "nt_addr", int'(nt_addr), 8192 + m_v % 4096);
      chk("R12", "at_addr", int'(at_addr),
          32'h23C0 + ((m_v / 1024) % 4) * 1024 + ((m_v / 128) % 8) * 8 + (m_v / 4) % 8);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] data);
    cpu_we = 1'b1; cpu_sel = sel; cpu_wdata = data;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic pulse_status();
    status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
  endtask

  task automatic pulse_acc();
    data_acc = 1'b1; @(negedge clk); data_acc = 1'b0;
  endtask

  task automatic walk_line(int ln, bit inject, int probe_dot, int probe_exp, string preq);
    for (int d = 0; d < 341; d++) begin
      line = 9'(ln); dot = 9'(d);
      data_acc  = inject && (d % 53 == 7);
      status_rd = inject && (d % 131 == 5);
      cpu_we    = inject && (d % 89 == 11);
      cpu_sel   = 2'd1;
      cpu_wdata = 8'(d * 7);
      @(negedge clk);
      if (d == probe_dot) chk(preq, "vert_fields", int'(vaddr) & 32'h7BE0, probe_exp);
    end
    data_acc = 1'b0; status_rd = 1'b0; cpu_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    cmp_en = 1'b1;
    idle(2);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "vaddr", int'(vaddr), 0);
    chk("R1", "fine_x", int'(fine_x), 0);
    chk("R1", "nt_addr", int'(nt_addr), 32'h2000);
    chk("R1", "at_addr", int'(at_addr), 32'h23C0);

    // R2, R4: register writes outside rendering
    cur_req = "R2/R4";
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h7D);
    chk("R2", "fine_x", int'(fine_x), 5);
    wr(2'd1, 8'h5E);
    wr(2'd3, 8'hFF);
    chk("R2", "fine_x after sel 3", int'(fine_x), 5);

    // R3: delayed commit
    cur_req = "R3";
    wr(2'd2, 8'h21);
    wr(2'd2, 8'h47);
    chk("R3", "vaddr before commit", int'(vaddr), 0);
    idle(1);
    chk("R3", "vaddr before commit", int'(vaddr), 0);
    idle(1);
    chk("R3", "vaddr committed", int'(vaddr), 32'h2147);

    // R11, R4: data-port stride outside rendering
    cur_req = "R11/R4";
    pulse_acc();
    chk("R11", "stride 1", int'(vaddr), 32'h2148);
    wr(2'd0, 8'h04);
    pulse_acc();
    chk("R4", "stride 32", int'(vaddr), 32'h2168);

    // R5: toggle rules
    cur_req = "R5";
    wr(2'd1, 8'h03);
    pulse_status();
    wr(2'd1, 8'h06);
    chk("R5", "first write after status", int'(fine_x), 6);
    status_rd = 1'b1;
    wr(2'd1, 8'h01);
    status_rd = 1'b0;
    wr(2'd1, 8'h02);
    chk("R5", "status wins same cycle", int'(fine_x), 2);

    // R7, R10, R8, R9, R6: coarse Y 29 seam through the pre-render reload
    cur_req = "R6/R7/R8/R9/R10";
    pulse_status();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd1, 8'hEF);
    render_en = 1'b1;
    walk_line(261, 1'b0, 304, 32'h73A0, "R10");
    walk_line(0, 1'b0, 256, 32'h0800, "R7");
    // coarse Y 31 wraps without a table flip
    line = 9'd240;
    wr(2'd1, 8'h00);
    wr(2'd1, 8'hFF);
    walk_line(261, 1'b0, 304, 32'h73E0, "R10");
    walk_line(0, 1'b0, 256, 32'h0000, "R7");

    // R13: commit landing on dot 328 beats the prefetch step
    cur_req = "R13";
    pulse_status();
    line = 9'd0;
    dot = 9'd325; wr(2'd2, 8'h15);
    dot = 9'd326; wr(2'd2, 8'h9F);
    dot = 9'd327; @(negedge clk);
    dot = 9'd328; @(negedge clk);
    chk("R13", "commit over step", int'(vaddr), 32'h159F);

    // R8, R11, R13: mixed traffic while rendering
    cur_req = "R8/R11/R13";
    walk_line(261, 1'b1, -1, 0, "R8");
    walk_line(0, 1'b1, -1, 0, "R8");
    walk_line(1, 1'b1, -1, 0, "R8");
    walk_line(239, 1'b1, -1, 0, "R8");
    walk_line(240, 1'b1, -1, 0, "R11");

    // R1: reset cancels a pending commit
    cur_req = "R1";
    render_en = 1'b0;
    pulse_status();
    wr(2'd2, 8'h12);
    cpu_we = 1'b1; cpu_sel = 2'd2; cpu_wdata = 8'h34;
    @(negedge clk);
    cpu_we = 1'b0; rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(3);
    chk("R1", "commit cancelled", int'(vaddr), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule